// File: doc/BRIEF.md
# Floppy Sector Read Verifier

This block sits behind the byte-recovery stage of an 8-inch hard-sectored floppy controller. It takes one raw 137-byte sector as the drive reads it, one byte for each cycle in which `in_valid` is high. It checks the sector against the track and sector numbers the host expects. The 128 payload bytes go out on a strobed byte stream. At the end of the sector the block raises a one-cycle `done` pulse with a pass bit and four separate error flags: track, sector, checksum and stop-byte.

Two layouts exist, and the block picks one from the expected track number when the sector's first byte arrives. On the low system tracks (0 to 5) a short header comes before the payload, and the payload is followed by a stop byte and a checksum. On the data tracks (6 upward) a longer header carries the sector number and a checksum byte, and two stop bytes close the sector. A raw mode passes all 137 bytes through with no checks. An abort input throws away a sector that ends early.

The control is a state machine with six states:

| State | Meaning |
| --- | --- |
| ST_SYNC | Idle, waiting for byte 0. |
| ST_HEAD | Header bytes before the payload. |
| ST_BODY | Payload bytes. |
| ST_TAIL | Trailer bytes after the payload. |
| ST_RAW | Bypass: all 137 bytes are forwarded. |
| ST_DONE | Report cycle. It also accepts the next sector's byte 0. |

Transitions:

- ST_SYNC or ST_DONE go to ST_HEAD on an accepted byte, or to ST_RAW if `raw_mode` is high at that byte.
- ST_DONE with no byte accepted goes to ST_SYNC.
- ST_HEAD goes to ST_BODY on the last header byte.
- ST_BODY goes to ST_TAIL on the last payload byte.
- ST_TAIL or ST_RAW go to ST_DONE on byte 136.
- From any state, `abort` goes to ST_SYNC.

Top module: `sector_verifier`

## Requirements
- R1: After reset, out_valid, done, pass and all four error flags are 0.
- R2: Byte 0 passes the track check only if bit 7 is 1 and bits 6:0 equal exp_track; otherwise track_err is reported. This applies on both layouts.
- R3: The layout is fixed when byte 0 is accepted. It is the system layout when exp_track is below 6, and the data layout otherwise.
- R4: Each forwarded byte appears on out_data with out_valid one cycle after it is accepted. The system layout forwards bytes 3..130, and the data layout forwards bytes 7..134, in order.
- R5: On the system layout, byte 131 must be 0xFF (else stop_err), and byte 132 must equal the modulo-256 sum of bytes 3..130 (else checksum_err). Bytes 1, 2 and 133..136 have no effect on any flag.
- R6: On the data layout, byte 1 must equal exp_sector, zero-extended to 8 bits, else sector_err. sector_err is never set on the system layout.
- R7: On the data layout, byte 4 must equal the modulo-256 sum of bytes 2..134 with byte 4 left out, else checksum_err. The sum restarts with every sector.
- R8: On the data layout, byte 135 must be 0xFF and byte 136 must be 0x00; a mismatch in either sets stop_err.
- R9: done is high for exactly one cycle, the cycle after byte 136 is accepted. In that cycle pass is 1 only if no flag is set. The flags and pass hold their values until the next done.
- R10: If raw_mode is high when byte 0 is accepted, all 137 bytes are forwarded unchanged, and done reports pass=1 with all flags at 0.
- R11: An abort discards any byte offered in the same cycle and returns the block to byte 0 with no done. The flags keep their previous values.
- R12: Cycles with in_valid low may come between any bytes, and they do not change the result.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A raw sector byte is offered |
| in_data | input | 8 | Raw sector byte |
| abort | input | 1 | Drop the current sector |
| raw_mode | input | 1 | Bypass checks; sampled at byte 0 |
| exp_track | input | TRACK_W | Expected track number |
| exp_sector | input | SECTOR_W | Expected sector number |
| out_valid | output | 1 | out_data holds a forwarded byte |
| out_data | output | 8 | Forwarded byte |
| done | output | 1 | One-cycle end-of-sector pulse |
| pass | output | 1 | Last sector had no error |
| track_err | output | 1 | Track or sync bit mismatch |
| sector_err | output | 1 | Sector number mismatch |
| checksum_err | output | 1 | Checksum mismatch |
| stop_err | output | 1 | Stop byte mismatch |

## Verification
The bench builds the block with its default parameters: a 7-bit track, a 5-bit sector and six system tracks. With these values every track from 0 to 76 can be swept, so both sides of the layout boundary between tracks 5 and 6 are covered. A single corrupted byte is placed at each of the 137 positions in turn, once on a system track and once on a data track. This shows exactly which positions affect which flag, and which positions are ignored. Raw mode, abort in the middle of a sector and idle gaps are each run on top of these sectors.

// File: rtl/sec_verify_pkg.sv
`timescale 1ns/1ps
package sec_verify_pkg;
    // Sector geometry. The offsets are decoded by the host format, so they are fixed.
    localparam int SECT_BYTES       = 137;
    localparam int PAY_BYTES        = 128;
    localparam int POS_W            = $clog2(SECT_BYTES);
    localparam int SYS_PAY_FIRST    = 3;
    localparam int SYS_STOP_POS     = 131;
    localparam int SYS_SUM_POS      = 132;
    localparam int DATA_SEC_POS     = 1;
    localparam int DATA_SUM_POS     = 4;
    localparam int DATA_SUM_FIRST   = 2;
    localparam int DATA_PAY_FIRST   = 7;
    localparam int DATA_STOP_FF_POS = 135;
    localparam int DATA_STOP_00_POS = 136;

    typedef enum logic [2:0] {
        ST_SYNC,
        ST_HEAD,
        ST_BODY,
        ST_TAIL,
        ST_RAW,
        ST_DONE
    } vstate_t;
endpackage

// File: rtl/sv_layout_sel.sv
`timescale 1ns/1ps
module sv_layout_sel #(
    parameter int TRACK_W        = 7,
    parameter int NUM_SYS_TRACKS = 6
) (
    input  logic [TRACK_W-1:0] exp_track,
    output logic               is_sys
);
    localparam logic [TRACK_W-1:0] SYS_LIMIT = TRACK_W'(NUM_SYS_TRACKS);

    always_comb is_sys = (exp_track < SYS_LIMIT);
endmodule

// File: rtl/sv_pos_decode.sv
`timescale 1ns/1ps
module sv_pos_decode
    import sec_verify_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  logic             is_sys,
    output logic             in_sum,
    output logic             sum_byte,
    output logic             stop_ff,
    output logic             stop_00,
    output logic             sec_byte
);
    localparam logic [POS_W-1:0] S_PF  = POS_W'(SYS_PAY_FIRST);
    localparam logic [POS_W-1:0] S_PL  = POS_W'(SYS_PAY_FIRST + PAY_BYTES - 1);
    localparam logic [POS_W-1:0] S_ST  = POS_W'(SYS_STOP_POS);
    localparam logic [POS_W-1:0] S_CK  = POS_W'(SYS_SUM_POS);
    localparam logic [POS_W-1:0] D_SF  = POS_W'(DATA_SUM_FIRST);
    localparam logic [POS_W-1:0] D_PL  = POS_W'(DATA_PAY_FIRST + PAY_BYTES - 1);
    localparam logic [POS_W-1:0] D_CK  = POS_W'(DATA_SUM_POS);
    localparam logic [POS_W-1:0] D_SC  = POS_W'(DATA_SEC_POS);
    localparam logic [POS_W-1:0] D_FF  = POS_W'(DATA_STOP_FF_POS);
    localparam logic [POS_W-1:0] D_00  = POS_W'(DATA_STOP_00_POS);

    always_comb begin
        if (is_sys) begin
            in_sum   = (pos >= S_PF) && (pos <= S_PL);
            sum_byte = (pos == S_CK);
            stop_ff  = (pos == S_ST);
            stop_00  = 1'b0;
            sec_byte = 1'b0;
        end else begin
            in_sum   = (pos >= D_SF) && (pos <= D_PL) && (pos != D_CK);
            sum_byte = (pos == D_CK);
            stop_ff  = (pos == D_FF);
            stop_00  = (pos == D_00);
            sec_byte = (pos == D_SC);
        end
    end
endmodule

// File: rtl/sv_csum_acc.sv
`timescale 1ns/1ps
module sv_csum_acc #(
    parameter int SUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic [SUM_W-1:0] add_byte,
    output logic [SUM_W-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sum <= '0;
        else if (clear)  sum <= '0;
        else if (add_en) sum <= sum + add_byte;
    end
endmodule

// File: rtl/sector_verifier.sv
`timescale 1ns/1ps
module sector_verifier
    import sec_verify_pkg::*;
#(
    parameter int TRACK_W        = 7,
    parameter int SECTOR_W       = 5,
    parameter int NUM_SYS_TRACKS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    input  logic                abort,
    input  logic                raw_mode,
    input  logic [TRACK_W-1:0]  exp_track,
    input  logic [SECTOR_W-1:0] exp_sector,
    output logic                out_valid,
    output logic [7:0]          out_data,
    output logic                done,
    output logic                pass,
    output logic                track_err,
    output logic                sector_err,
    output logic                checksum_err,
    output logic                stop_err
);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(SECT_BYTES - 1);
    localparam logic [POS_W-1:0] S_HEAD_E  = POS_W'(SYS_PAY_FIRST - 1);
    localparam logic [POS_W-1:0] D_HEAD_E  = POS_W'(DATA_PAY_FIRST - 1);
    localparam logic [POS_W-1:0] S_BODY_E  = POS_W'(SYS_PAY_FIRST + PAY_BYTES - 1);
    localparam logic [POS_W-1:0] D_BODY_E  = POS_W'(DATA_PAY_FIRST + PAY_BYTES - 1);

    vstate_t          state_q, nxt;
    logic [POS_W-1:0] pos_q;
    logic             sys_q, raw_q;
    logic             trk_bad_q, sec_bad_q, stop_bad_q;
    logic [7:0]       ck_q;
    logic [7:0]       csum;
    logic             sys_now;
    logic             dec_in_sum, dec_sum_byte, dec_stop_ff, dec_stop_00, dec_sec;

    logic             accept, at_start, fwd, last_byte, sum_bad, tail_stop_bad;
    logic [POS_W-1:0] head_end, body_end;

    sv_layout_sel #(.TRACK_W(TRACK_W), .NUM_SYS_TRACKS(NUM_SYS_TRACKS)) u_layout (
        .exp_track (exp_track),
        .is_sys    (sys_now)
    );

    sv_pos_decode u_dec (
        .pos      (pos_q),
        .is_sys   (sys_q),
        .in_sum   (dec_in_sum),
        .sum_byte (dec_sum_byte),
        .stop_ff  (dec_stop_ff),
        .stop_00  (dec_stop_00),
        .sec_byte (dec_sec)
    );

    sv_csum_acc #(.SUM_W(8)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (abort || (accept && at_start)),
        .add_en   (accept && dec_in_sum && !raw_q && !at_start),
        .add_byte (in_data),
        .sum      (csum)
    );

    always_comb begin
        accept        = in_valid && !abort;
        at_start      = (state_q == ST_SYNC) || (state_q == ST_DONE);
        head_end      = sys_q ? S_HEAD_E : D_HEAD_E;
        body_end      = sys_q ? S_BODY_E : D_BODY_E;
        fwd           = accept && (at_start ? raw_mode
                                            : ((state_q == ST_BODY) || (state_q == ST_RAW)));
        last_byte     = accept && !at_start && (pos_q == LAST_POS);
        sum_bad       = (csum != ck_q);
        tail_stop_bad = dec_stop_00 && (in_data != 8'h00);
    end

    // Next-state logic
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_SYNC, ST_DONE: begin
                if (accept) nxt = raw_mode ? ST_RAW : ST_HEAD;
                else        nxt = ST_SYNC;
            end
            ST_HEAD: if (accept && pos_q == head_end) nxt = ST_BODY;
            ST_BODY: if (accept && pos_q == body_end) nxt = ST_TAIL;
            ST_TAIL: if (accept && pos_q == LAST_POS) nxt = ST_DONE;
            ST_RAW:  if (accept && pos_q == LAST_POS) nxt = ST_DONE;
            default: nxt = ST_SYNC;
        endcase
        if (abort) nxt = ST_SYNC;
    end

    // State register, byte position and per-sector check latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_SYNC;
            pos_q      <= '0;
            sys_q      <= 1'b0;
            raw_q      <= 1'b0;
            trk_bad_q  <= 1'b0;
            sec_bad_q  <= 1'b0;
            stop_bad_q <= 1'b0;
            ck_q       <= '0;
        end else begin
            state_q <= nxt;
            if (abort)       pos_q <= '0;
            else if (accept) pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
            if (accept) begin
                if (at_start) begin
                    sys_q      <= sys_now;
                    raw_q      <= raw_mode;
                    trk_bad_q  <= !(in_data[7] && (in_data[6:0] == 7'(exp_track)));
                    sec_bad_q  <= 1'b0;
                    stop_bad_q <= 1'b0;
                    ck_q       <= '0;
                end else begin
                    if (dec_sec)      sec_bad_q <= (in_data != 8'(exp_sector));
                    if (dec_stop_ff && in_data != 8'hFF) stop_bad_q <= 1'b1;
                    if (dec_sum_byte) ck_q <= in_data;
                end
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_data     <= '0;
            done         <= 1'b0;
            pass         <= 1'b0;
            track_err    <= 1'b0;
            sector_err   <= 1'b0;
            checksum_err <= 1'b0;
            stop_err     <= 1'b0;
        end else begin
            out_valid <= fwd;
            if (fwd) out_data <= in_data;
            done <= last_byte;
            if (last_byte) begin
                if (raw_q) begin
                    pass         <= 1'b1;
                    track_err    <= 1'b0;
                    sector_err   <= 1'b0;
                    checksum_err <= 1'b0;
                    stop_err     <= 1'b0;
                end else begin
                    track_err    <= trk_bad_q;
                    sector_err   <= sec_bad_q;
                    checksum_err <= sum_bad;
                    stop_err     <= stop_bad_q || tail_stop_bad;
                    pass         <= !(trk_bad_q || sec_bad_q || sum_bad ||
                                      stop_bad_q || tail_stop_bad);
                end
            end
        end
    end
endmodule

// File: rtl/sv_checker.sv
`timescale 1ns/1ps
module sv_checker
    import sec_verify_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic abort,
    input logic out_valid,
    input logic done,
    input logic pass,
    input logic track_err,
    input logic sector_err,
    input logic checksum_err,
    input logic stop_err
);
    logic [POS_W:0] fwd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              fwd_cnt <= '0;
        else if (done || abort)  fwd_cnt <= '0;
        else if (out_valid)      fwd_cnt <= fwd_cnt + 1'b1;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R9
    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && !abort));                              // R9
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({pass, track_err, sector_err, checksum_err, stop_err})); // R9
    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!done && !out_valid));                                 // R11
    AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && !abort));                         // R4
    AST_OUT_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (fwd_cnt < (POS_W+1)'(SECT_BYTES)));                // R10
endmodule

bind sector_verifier sv_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .abort        (abort),
    .out_valid    (out_valid),
    .done         (done),
    .pass         (pass),
    .track_err    (track_err),
    .sector_err   (sector_err),
    .checksum_err (checksum_err),
    .stop_err     (stop_err)
);

// File: tb/sim_sector_verifier.sv
`timescale 1ns/1ps
module sim_sector_verifier;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       abort = 1'b0;
    logic       raw_mode = 1'b0;
    logic [6:0] exp_track = '0;
    logic [4:0] exp_sector = '0;
    logic       out_valid, done, pass, track_err, sector_err, checksum_err, stop_err;
    logic [7:0] out_data;

    always #2.5 clk = ~clk;   // 200 MHz

    sector_verifier u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .abort(abort), .raw_mode(raw_mode), .exp_track(exp_track),
        .exp_sector(exp_sector), .out_valid(out_valid), .out_data(out_data),
        .done(done), .pass(pass), .track_err(track_err), .sector_err(sector_err),
        .checksum_err(checksum_err), .stop_err(stop_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] sec [0:136];
    logic [7:0] got [0:199];
    int got_n = 0;
    int done_n = 0;
    logic [3:0] cap_flags = '0;
    logic cap_pass = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (got_n < 200) got[got_n] = out_data;
                got_n++;
            end
            if (done) begin
                done_n++;
                cap_flags = {track_err, sector_err, checksum_err, stop_err};
                cap_pass  = pass;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Good sector per the layout requirements (R5, R6, R7, R8)
    task automatic build(input int trk, input int s, input int seed);
        logic [7:0] sm;
        for (int i = 0; i < 137; i++) sec[i] = 8'((seed * 31 + i * 13) ^ (i >> 2));
        sec[0] = {1'b1, 7'(trk)};
        sm = 8'h00;
        if (trk < 6) begin
            for (int i = 3; i <= 130; i++) sm = sm + sec[i];
            sec[131] = 8'hFF;
            sec[132] = sm;
        end else begin
            sec[1] = 8'(s);
            for (int i = 2; i <= 134; i++) if (i != 4) sm = sm + sec[i];
            sec[4]   = sm;
            sec[135] = 8'hFF;
            sec[136] = 8'h00;
        end
    endtask

    task automatic drive_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic run_sector(input int trk, input int s, input bit raw, input bit gaps, input string tag);
        logic [3:0] ef;
        logic [7:0] sm;
        int pf, pc, bad;
        exp_track  = 7'(trk);
        exp_sector = 5'(s);
        raw_mode   = raw;
        got_n = 0;
        done_n = 0;
        for (int i = 0; i < 137; i++) begin
            drive_byte(sec[i]);
            if (gaps && (i % 5 == 2)) begin @(posedge clk); #1; end   // R12 idle gaps
        end
        repeat (2) @(posedge clk);
        #1;
        // Expected result from the requirements
        sm = 8'h00;
        if (raw) begin
            ef = 4'b0000; pf = 0; pc = 137;                           // R10
        end else if (trk < 6) begin                                   // R3 system layout
            for (int i = 3; i <= 130; i++) sm = sm + sec[i];
            ef[3] = !(sec[0][7] && sec[0][6:0] == 7'(trk));           // R2
            ef[2] = 1'b0;                                             // R6
            ef[1] = (sec[132] != sm);                                 // R5
            ef[0] = (sec[131] != 8'hFF);                              // R5
            pf = 3; pc = 128;
        end else begin                                                // R3 data layout
            for (int i = 2; i <= 134; i++) if (i != 4) sm = sm + sec[i];
            ef[3] = !(sec[0][7] && sec[0][6:0] == 7'(trk));           // R2
            ef[2] = (sec[1] != 8'(s));                                // R6
            ef[1] = (sec[4] != sm);                                   // R7
            ef[0] = (sec[135] != 8'hFF) || (sec[136] != 8'h00);       // R8
            pf = 7; pc = 128;
        end
        chk(done_n == 1, {tag, " R9 done count"}, 32'(done_n), 32'd1);
        chk(cap_flags == ef, {tag, " R2/R5/R6/R7/R8/R10 flags"}, 32'(cap_flags), 32'(ef));
        chk(cap_pass == (ef == 4'b0000), {tag, " R9 pass"}, 32'(cap_pass), 32'(ef == 4'b0000));
        chk(got_n == pc, {tag, " R4 forwarded count"}, 32'(got_n), 32'(pc));
        bad = -1;
        for (int j = 0; j < pc && j < got_n; j++)
            if (bad < 0 && got[j] != sec[pf + j]) bad = j;
        chk(bad < 0, {tag, " R4 payload bytes"}, (bad < 0) ? 32'd0 : 32'(got[bad]),
            (bad < 0) ? 32'd0 : 32'(sec[pf + bad]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog actual=%0d expected=<200000 cycles", 200000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [3:0] prev_flags;
        logic       prev_pass;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk({out_valid, done, pass, track_err, sector_err, checksum_err, stop_err} == 7'b0,
            "R1 reset outputs", 32'({out_valid, done, pass, track_err, sector_err, checksum_err, stop_err}), 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // Good sectors on every track, both layouts around the 5/6 boundary (R3, R12)
        for (int t = 0; t <= 76; t++) begin
            build(t, (t * 7) % 32, t);
            run_sector(t, (t * 7) % 32, 1'b0, (t % 2) == 1, "R3 sweep");
        end

        // Single-byte corruption at every position (R2, R5, R6, R7, R8)
        for (int k = 0; k < 137; k++) begin
            build(2, 0, k + 100);
            sec[k] = sec[k] ^ 8'h21;
            run_sector(2, 0, 1'b0, 1'b0, "R5 corrupt sys");
        end
        for (int k = 0; k < 137; k++) begin
            build(50, 17, k + 300);
            sec[k] = sec[k] ^ 8'h21;
            run_sector(50, 17, 1'b0, (k % 3) == 0, "R7 corrupt data");
        end

        // Sync bit missing but track bits correct (R2)
        build(40, 3, 7);
        sec[0] = sec[0] & 8'h7F;
        run_sector(40, 3, 1'b0, 1'b0, "R2 no sync");

        // Wrong expected sector: flagged on data layout only (R6)
        build(20, 9, 8);
        run_sector(20, 10, 1'b0, 1'b0, "R6 data wrong sector");
        build(4, 9, 9);
        run_sector(4, 10, 1'b0, 1'b0, "R6 sys sector ignored");

        // Raw mode with corrupted content (R10)
        build(1, 0, 11);
        sec[131] = 8'h00; sec[0] = 8'h05;
        run_sector(1, 0, 1'b1, 1'b0, "R10 raw sys");
        build(60, 2, 12);
        sec[4] = sec[4] + 8'd1; sec[136] = 8'h55;
        run_sector(60, 2, 1'b1, 1'b1, "R10 raw data");

        // Abort: make flags nonzero first, then abort partial sectors (R11)
        build(30, 5, 13);
        sec[135] = 8'h00;
        run_sector(30, 5, 1'b0, 1'b0, "R11 setup");
        prev_flags = {track_err, sector_err, checksum_err, stop_err};
        prev_pass  = pass;
        got_n = 0; done_n = 0;
        raw_mode = 1'b0;
        build(30, 5, 14);
        for (int i = 0; i < 60; i++) drive_byte(sec[i]);
        abort = 1'b1; in_valid = 1'b1; in_data = 8'hAA;               // byte dropped
        @(posedge clk); #1;
        abort = 1'b0; in_valid = 1'b0;
        repeat (3) @(posedge clk); #1;
        chk(done_n == 0, "R11 no done after abort", 32'(done_n), 32'd0);
        chk({track_err, sector_err, checksum_err, stop_err, pass} == {prev_flags, prev_pass},
            "R11 flags unchanged", 32'({track_err, sector_err, checksum_err, stop_err, pass}),
            32'({prev_flags, prev_pass}));
        run_sector(30, 5, 1'b0, 1'b0, "R11 after abort");
        // Abort on an idle cycle in the middle of a system sector, then restart
        build(3, 0, 15);
        for (int i = 0; i < 100; i++) drive_byte(sec[i]);
        abort = 1'b1;
        @(posedge clk); #1;
        abort = 1'b0;
        build(3, 0, 16);
        run_sector(3, 0, 1'b0, 1'b1, "R11 restart sys");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule